// File: doc/BRIEF.md
# Link word format checker

This block watches the 36-bit words that a parallel link deserializer delivers, one per receive clock, and checks the sideband fields that travel next to 32 payload lanes. It finds the one-in-eight frame marker and locks onto it. It rebuilds an 8-bit bunch-crossing number that arrives one bit per word and checks that successive numbers step through the counting sequence. It checks parity on every word and checks that the format flag stays clear. Each class of fault has a saturating counter and a sticky flag. A small read port selects one counter at a time, and a synchronous clear input restarts the whole checker.

Words enter on a valid/ready stream. The checker never back-pressures: `in_ready` is held high, and a word is consumed on every rising clock edge where `in_valid` is high. A cycle with `in_valid` low consumes nothing and does not advance the frame position. The payload lanes pass through the parity check only. Their pseudo-random content is not checked.

Field positions inside a word: bits 0..31 are payload lanes. Bit 32 is the serial bunch-crossing bit. Bit 33 is the format flag. Bit 34 is the frame marker. Bit 35 is parity.

Top module: `link_word_checker`

## Requirements
- R1: `in_ready` is 1 whenever `rst_n` is 1. A cycle with `in_valid` = 0 changes no counter, no flag, no lock state and no frame position, whatever `in_word` holds.
- R2: An accepted word with an odd number of ones across all 36 bits breaks the parity rule, where bit 35 must equal the XOR of bits 0..34. Each such word adds one to the parity counter (`rd_sel` = 0) and sets `err_parity`. Parity is checked whether or not the checker is locked.
- R3: Each accepted word with bit 33 = 1 adds one to the format counter (`rd_sel` = 3) and sets `err_format`.
- R4: Out of reset the checker is unlocked. While unlocked, an accepted word with bit 34 = 1 that comes exactly 8 accepted words after the previous marker sets `locked`. `locked` is visible in the cycle after that word. Markers at any other spacing do not lock.
- R5: While locked, the accepted words form 8-word windows, and position 0 of each window is the word that carries the marker. A window counts as bad if the marker is missing at position 0 or is present at any other position. Each bad window adds one to the framing counter (`rd_sel` = 1) and sets `err_frame` once, after its last word. Nothing is counted as framing error while unlocked.
- R6: Four bad windows in a row clear `locked` after the fourth one. A good window resets the run.
- R7: Bit 32 of the 8 window words forms the bunch-crossing number, least-significant bit first, starting with the marker word. After the last word of a window, `bx_num` shows that number.
- R8: The first number gathered after lock is taken as the reference without a check, whatever its value. The number of a window that ends with loss of lock is shown but not checked.
- R9: Every other gathered number must be valid (1..159) and equal the previous number plus one, where 159 is followed by 1. Each mismatch adds one to the sequence counter (`rd_sel` = 2) and sets `err_seq`. The received number then becomes the new reference.
- R10: Each counter is `CNT_W` bits wide and holds at all ones instead of wrapping.
- R11: A sticky flag is set by every error event of its class and stays set until a clear.
- R12: `clr` = 1 at a clock edge zeroes all counters, flags, `bx_num`, the lock state and the reference. It takes priority over a word accepted at the same edge.
- R13: `rd_data` combinationally shows the counter chosen by `rd_sel`: 0 for parity, 1 for framing, 2 for sequence, 3 for format.
- R14: After reset, `locked` and all flags are 0, `bx_num` is 0 and every counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of counters, flags and lock |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | Always 1; the checker never stalls |
| in_word | input | LANES+4 (36) | Received word |
| rd_sel | input | 2 | Counter select for the read port |
| rd_data | output | CNT_W (16) | Selected error counter |
| locked | output | 1 | Frame lock status |
| bx_num | output | BX_W (8) | Last fully gathered bunch-crossing number |
| err_parity | output | 1 | Sticky parity error flag |
| err_frame | output | 1 | Sticky framing error flag |
| err_seq | output | 1 | Sticky sequence error flag |
| err_format | output | 1 | Sticky format error flag |

## Verification
The hardest state to reach from the ports is loss of lock. It needs a real lock first, then exactly four bad windows in a row, and each window must be bad in a different way: a shifted marker, a missing marker, an extra marker, and a marker in the last slot. The bench therefore sends whole frames with a chosen marker mask. It puts one good window in the middle to show that the run restarts. It sends an out-of-order number in the window where lock is lost, to show that this number is not checked. The bench also sweeps the marker spacing from 1 to 12 after separate clears, so that only spacing 8 locks. It runs the number sequence across two wraps, and it uses an 8-bit counter build to reach saturation in a few hundred words.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
  // Read-port selector codes for the error counters
  typedef enum logic [1:0] {
    SEL_PARITY = 2'd0,
    SEL_FRAME  = 2'd1,
    SEL_SEQ    = 2'd2,
    SEL_FORMAT = 2'd3
  } err_sel_e;

  localparam int NUM_ERR = 4;
endpackage

// File: rtl/lwc_frame_track.sv
module lwc_frame_track #(
  parameter int FRAME_LEN  = 8,
  parameter int UNLOCK_RUN = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_i,
  input  logic                         acc_i,
  input  logic                         mark_i,
  output logic                         locked_o,
  output logic [$clog2(FRAME_LEN)-1:0] pos_o,
  output logic                         frame_on_o,
  output logic                         win_end_o,
  output logic                         drop_o,
  output logic                         frame_err_o
);
  localparam int PW   = $clog2(FRAME_LEN);
  localparam int GW   = $clog2(FRAME_LEN + 1);
  localparam int RW   = $clog2(UNLOCK_RUN + 1);
  localparam logic [PW-1:0] LAST    = PW'(FRAME_LEN - 1);
  localparam logic [GW-1:0] GAP_HIT = GW'(FRAME_LEN - 1);
  localparam logic [GW-1:0] GAP_SAT = GW'(FRAME_LEN);
  localparam logic [RW-1:0] RUN_END = RW'(UNLOCK_RUN - 1);

  logic          locked_q;
  logic [PW-1:0] pos_q;
  logic [GW-1:0] gap_q;
  logic          seen_q;
  logic          bad_q;
  logic [RW-1:0] run_q;

  logic lock_now, mismatch, win_end, bad_win, drop;

  always_comb begin
    lock_now = acc_i && !locked_q && mark_i && seen_q && (gap_q == GAP_HIT);
    mismatch = locked_q && (mark_i != (pos_q == '0));
    win_end  = acc_i && locked_q && (pos_q == LAST);
    bad_win  = win_end && (bad_q || mismatch);
    drop     = bad_win && (run_q == RUN_END);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      pos_q    <= '0;
      gap_q    <= '0;
      seen_q   <= 1'b0;
      bad_q    <= 1'b0;
      run_q    <= '0;
    end else if (clr_i) begin
      locked_q <= 1'b0;
      pos_q    <= '0;
      gap_q    <= '0;
      seen_q   <= 1'b0;
      bad_q    <= 1'b0;
      run_q    <= '0;
    end else if (acc_i) begin
      if (!locked_q) begin
        if (mark_i) begin
          seen_q <= 1'b1;
          gap_q  <= '0;
          if (lock_now) begin
            locked_q <= 1'b1;
            pos_q    <= PW'(1);
            bad_q    <= 1'b0;
            run_q    <= '0;
          end
        end else if (gap_q != GAP_SAT) begin
          gap_q <= gap_q + 1'b1;
        end
      end else begin
        pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
        if (win_end) begin
          bad_q <= 1'b0;
          if (drop) begin
            locked_q <= 1'b0;
            seen_q   <= 1'b0;
            gap_q    <= '0;
            run_q    <= '0;
          end else if (bad_win) begin
            run_q <= run_q + 1'b1;
          end else begin
            run_q <= '0;
          end
        end else begin
          bad_q <= bad_q || mismatch;
        end
      end
    end
  end

  assign locked_o    = locked_q;
  assign pos_o       = locked_q ? pos_q : '0;
  assign frame_on_o  = acc_i && (locked_q || lock_now);
  assign win_end_o   = win_end;
  assign drop_o      = drop;
  assign frame_err_o = bad_win;

  // R4
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(acc_i && mark_i && !clr_i));

  // R6
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_q) |-> $past(clr_i || (acc_i && pos_q == LAST)));

  // R1
  pos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_i && !clr_i) |=> $stable(pos_q) && $stable(locked_q));
endmodule

// File: rtl/lwc_bx_seq.sv
module lwc_bx_seq #(
  parameter int BX_W   = 8,
  parameter int BX_MIN = 1,
  parameter int BX_MAX = 159
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    bit_en_i,
  input  logic [$clog2(BX_W)-1:0] pos_i,
  input  logic                    bit_i,
  input  logic                    end_i,
  input  logic                    skip_i,
  output logic [BX_W-1:0]         bx_o,
  output logic                    seq_err_o
);
  localparam logic [BX_W-1:0] V_MIN = BX_W'(BX_MIN);
  localparam logic [BX_W-1:0] V_MAX = BX_W'(BX_MAX);

  logic [BX_W-1:0] acc_q;
  logic [BX_W-1:0] bx_q;
  logic            ref_ok_q;
  logic [BX_W-1:0] gathered;
  logic [BX_W-1:0] expect_nx;
  logic            in_range;

  always_comb begin
    gathered           = acc_q;
    gathered[BX_W-1]   = bit_i;
    expect_nx          = (bx_q == V_MAX) ? V_MIN : bx_q + 1'b1;
    in_range           = (gathered >= V_MIN) && (gathered <= V_MAX);
    seq_err_o          = end_i && ref_ok_q && !skip_i &&
                         (!in_range || gathered != expect_nx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      bx_q     <= '0;
      ref_ok_q <= 1'b0;
    end else if (clr_i) begin
      acc_q    <= '0;
      bx_q     <= '0;
      ref_ok_q <= 1'b0;
    end else begin
      if (bit_en_i) acc_q[pos_i] <= bit_i;
      if (end_i) begin
        bx_q     <= gathered;
        ref_ok_q <= !skip_i;
      end
    end
  end

  assign bx_o = bx_q;

  // R7
  bx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!end_i && !clr_i) |=> $stable(bx_o));

  // R8
  ref_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && skip_i && !clr_i) |=> !ref_ok_q);
endmodule

// File: rtl/lwc_err_cnt.sv
module lwc_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (hit_i) begin
      flag_q <= 1'b1;
      if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP && !clr_i) |=> cnt_q == TOP);

  // R10
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/link_word_checker.sv
module link_word_checker
  import lwc_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int BX_W       = 8,
  parameter int BX_MAX     = 159,
  parameter int CNT_W      = 16,
  parameter int UNLOCK_RUN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [LANES+3:0]   in_word,
  input  logic [1:0]         rd_sel,
  output logic [CNT_W-1:0]   rd_data,
  output logic               locked,
  output logic [BX_W-1:0]    bx_num,
  output logic               err_parity,
  output logic               err_frame,
  output logic               err_seq,
  output logic               err_format
);
  localparam int FRAME_LEN = BX_W;
  localparam int PW        = $clog2(FRAME_LEN);
  localparam int BIT_BX    = LANES;
  localparam int BIT_FMT   = LANES + 1;
  localparam int BIT_MARK  = LANES + 2;

  logic          acc;
  logic [PW-1:0] pos;
  logic          frame_on, win_end, drop, frame_err, seq_err;
  logic [NUM_ERR-1:0] hit;
  logic [NUM_ERR-1:0] flag;
  logic [CNT_W-1:0]   cnt [NUM_ERR];

  assign in_ready = 1'b1;
  assign acc      = in_valid && in_ready;

  lwc_frame_track #(
    .FRAME_LEN  (FRAME_LEN),
    .UNLOCK_RUN (UNLOCK_RUN)
  ) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr),
    .acc_i       (acc),
    .mark_i      (in_word[BIT_MARK]),
    .locked_o    (locked),
    .pos_o       (pos),
    .frame_on_o  (frame_on),
    .win_end_o   (win_end),
    .drop_o      (drop),
    .frame_err_o (frame_err)
  );

  lwc_bx_seq #(
    .BX_W   (BX_W),
    .BX_MIN (1),
    .BX_MAX (BX_MAX)
  ) u_bx (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr),
    .bit_en_i  (frame_on),
    .pos_i     (pos),
    .bit_i     (in_word[BIT_BX]),
    .end_i     (win_end),
    .skip_i    (drop),
    .bx_o      (bx_num),
    .seq_err_o (seq_err)
  );

  always_comb begin
    hit             = '0;
    hit[SEL_PARITY] = acc && (^in_word);
    hit[SEL_FRAME]  = frame_err;
    hit[SEL_SEQ]    = seq_err;
    hit[SEL_FORMAT] = acc && in_word[BIT_FMT];
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_cnt
    lwc_err_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .hit_i  (hit[g]),
      .cnt_o  (cnt[g]),
      .flag_o (flag[g])
    );
  end

  assign rd_data    = cnt[rd_sel];
  assign err_parity = flag[SEL_PARITY];
  assign err_frame  = flag[SEL_FRAME];
  assign err_seq    = flag[SEL_SEQ];
  assign err_format = flag[SEL_FORMAT];

  // R2
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (^in_word) && !clr) |=> err_parity);

  // R3
  format_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[BIT_FMT] && !clr) |=> err_format);

  // R12
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!locked && !err_parity && !err_frame && !err_seq && !err_format));
endmodule

// File: tb/link_word_checker_bench.sv
module link_word_checker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int SAT = 255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [35:0] in_word = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [CW-1:0] rd_data;
  logic        locked;
  logic [7:0]  bx_num;
  logic        err_parity, err_frame, err_seq, err_format;

  int n_chk = 0;
  int n_fail = 0;
  int e_par, e_frm, e_seq, e_fmt;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_word_checker #(.CNT_W(CW)) u_link_word_checker (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .rd_sel(rd_sel),
    .rd_data(rd_data), .locked(locked), .bx_num(bx_num),
    .err_parity(err_parity), .err_frame(err_frame),
    .err_seq(err_seq), .err_format(err_format)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clip(input int v);
    return (v > SAT) ? SAT : v;
  endfunction

  function automatic logic [35:0] mk_word(input logic bxb, input logic fmt,
                                          input logic mark, input logic bad);
    logic [35:0] w;
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    w[31:0] = rng;
    w[32] = bxb;
    w[33] = fmt;
    w[34] = mark;
    w[35] = (^w[34:0]) ^ bad;
    return w;
  endfunction

  task automatic put_word(input logic [35:0] w);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] v, input logic [7:0] mmask);
    for (int w = 0; w < 8; w++) put_word(mk_word(v[w], 1'b0, mmask[w], 1'b0));
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    e_par = 0; e_frm = 0; e_seq = 0; e_fmt = 0;
  endtask

  task automatic read_cnt(input logic [1:0] s, output int v);
    rd_sel = s;
    #1;
    v = int'(rd_data);
  endtask

  task automatic check_all(input string tag);
    int v;
    read_cnt(2'd0, v); check(v == clip(e_par), {tag, " R2 R13 parity count"}, v, clip(e_par));
    read_cnt(2'd1, v); check(v == clip(e_frm), {tag, " R5 R13 framing count"}, v, clip(e_frm));
    read_cnt(2'd2, v); check(v == clip(e_seq), {tag, " R9 R13 sequence count"}, v, clip(e_seq));
    read_cnt(2'd3, v); check(v == clip(e_fmt), {tag, " R3 R13 format count"}, v, clip(e_fmt));
    check(err_parity == (e_par > 0), {tag, " R11 parity flag"}, err_parity, e_par > 0);
    check(err_frame  == (e_frm > 0), {tag, " R11 framing flag"}, err_frame, e_frm > 0);
    check(err_seq    == (e_seq > 0), {tag, " R11 sequence flag"}, err_seq, e_seq > 0);
    check(err_format == (e_fmt > 0), {tag, " R11 format flag"}, err_format, e_fmt > 0);
  endtask

  task automatic lock_at(input logic [7:0] ref_v);
    send_frame(8'd0, 8'h01);
    send_frame(ref_v, 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [35:0] w;
    e_par = 0; e_frm = 0; e_seq = 0; e_fmt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R14 reset state
    check(locked == 1'b0, "R14 locked after reset", locked, 0);
    check(bx_num == 8'd0, "R14 bx_num after reset", bx_num, 0);
    check(in_ready == 1'b1, "R1 in_ready high", in_ready, 1);
    check_all("R14");

    // R1 words offered with in_valid low have no effect
    for (int i = 0; i < 24; i++) begin
      w = mk_word(1'b1, 1'b1, (i % 8) == 0, 1'b1);
      in_word = w;
      @(negedge clk);
    end
    check(locked == 1'b0, "R1 idle markers do not lock", locked, 0);
    check_all("R1");

    // R2 R3 single-bit flips of every bit position
    for (int k = 0; k < 36; k++) begin
      w = mk_word(1'b0, 1'b0, 1'b0, 1'b0);
      w[k] = ~w[k];
      put_word(w);
      e_par++;
      if (k == 33) e_fmt++;
    end
    // double flips inside the lanes keep parity even
    for (int k = 0; k < 31; k++) begin
      w = mk_word(1'b0, 1'b0, 1'b0, 1'b0);
      w[k] = ~w[k];
      w[k+1] = ~w[k+1];
      put_word(w);
    end
    // format flag with parity kept even
    for (int k = 0; k < 3; k++) begin
      put_word(mk_word(1'b0, 1'b1, 1'b0, 1'b0));
      e_fmt++;
    end
    check_all("R2R3 sweep");

    // R4 marker spacing sweep, only spacing 8 locks
    for (int g = 1; g <= 12; g++) begin
      do_clear();
      put_word(mk_word(1'b0, 1'b0, 1'b1, 1'b0));
      for (int i = 0; i < g - 1; i++) put_word(mk_word(1'b0, 1'b0, 1'b0, 1'b0));
      check(locked == 1'b0, "R4 not locked before second marker", locked, 0);
      put_word(mk_word(1'b0, 1'b0, 1'b1, 1'b0));
      check(locked == (g == 8), "R4 lock versus marker spacing", locked, g == 8);
    end

    // R7 R8 R9 long sequence across wraps
    do_clear();
    lock_at(8'd150);
    check(locked == 1'b1, "R4 locked by frames", locked, 1);
    check(bx_num == 8'd150, "R7 R8 reference number shown", bx_num, 150);
    v = 8'd150;
    for (int i = 0; i < 330; i++) begin
      v = (v == 8'd159) ? 8'd1 : v + 8'd1;
      send_frame(v, 8'h01);
      check(bx_num == v, "R7 gathered number", bx_num, v);
    end
    check_all("R9 wrap sweep");

    // R8 invalid first number is not checked; R9 error cases
    do_clear();
    lock_at(8'd0);
    send_frame(8'd1, 8'h01);
    check_all("R8 first unchecked");
    send_frame(8'd5, 8'h01);   e_seq++;   // expected 2
    send_frame(8'd6, 8'h01);
    send_frame(8'd159, 8'h01); e_seq++;   // expected 7
    send_frame(8'd1, 8'h01);
    send_frame(8'd159, 8'h01); e_seq++;
    send_frame(8'd160, 8'h01); e_seq++;   // out of range
    send_frame(8'd161, 8'h01); e_seq++;   // out of range
    send_frame(8'd0, 8'h01);   e_seq++;   // zero never valid
    check(bx_num == 8'd0, "R7 zero shown", bx_num, 0);
    check_all("R9 errors");

    // R5 R6 bad windows and loss of lock
    do_clear();
    lock_at(8'd10);
    send_frame(8'd11, 8'h08); e_frm++;    // shifted marker
    send_frame(8'd12, 8'h01);             // good window resets run
    send_frame(8'd13, 8'h00); e_frm++;    // missing marker
    send_frame(8'd14, 8'h21); e_frm++;    // extra marker
    send_frame(8'd15, 8'h80); e_frm++;    // marker in last slot
    check(locked == 1'b1, "R6 three bad windows keep lock", locked, 1);
    send_frame(8'd99, 8'h04); e_frm++;    // fourth in a row
    check(locked == 1'b0, "R6 fourth bad window drops lock", locked, 0);
    check(bx_num == 8'd99, "R8 number of dropping window shown", bx_num, 99);
    send_frame(8'd3, 8'h00);
    send_frame(8'd4, 8'h00);
    check(locked == 1'b0, "R5 unlocked stays unlocked", locked, 0);
    check_all("R5R6");

    // R10 saturation, R11 sticky
    do_clear();
    for (int i = 0; i < 300; i++) begin
      put_word(mk_word(1'b0, 1'b0, 1'b0, 1'b1));
      e_par++;
    end
    for (int i = 0; i < 260; i++) begin
      put_word(mk_word(1'b0, 1'b1, 1'b0, 1'b0));
      e_fmt++;
    end
    for (int i = 0; i < 20; i++) put_word(mk_word(1'b0, 1'b0, 1'b0, 1'b0));
    check_all("R10 saturation");

    // R12 clear wins over a faulty word at the same edge
    do_clear();
    lock_at(8'd40);
    send_frame(8'd50, 8'h02);
    e_seq++; e_frm++;
    check_all("R12 before clear");
    clr = 1'b1;
    put_word(mk_word(1'b1, 1'b1, 1'b1, 1'b1));
    clr = 1'b0;
    e_par = 0; e_frm = 0; e_seq = 0; e_fmt = 0;
    check(locked == 1'b0, "R12 lock cleared", locked, 0);
    check(bx_num == 8'd0, "R12 bx_num cleared", bx_num, 0);
    check_all("R12 after clear");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule